// File: doc/BRIEF.md
# Asymmetric PWM Generator with Shadowed Period and Compare

This block produces one pulse-width-modulated output from a free-running cycle counter. Software sets a period length and a compare (high-time) value, both counted in clock cycles, through a small byte-addressed register port that accepts 16-bit and 32-bit accesses. The output is high while the counter is below the compare value and low for the rest of the period.

Each of the period and compare settings has two copies. The active copy drives the waveform and takes effect as soon as it is written. The shadow copy is held until the running period ends. Then it is moved into the active copy, so a running waveform is never cut short. A control word has one bit that starts and stops the counter and another that lets the waveform reach the pin.

Top module: `apwm_shadow`

## Requirements
- R1: After a synchronous reset, every register reads as zero and `pwm_out` is low.
- R2: The register map is as follows. The active period is at byte offset 0x08 and the active compare value is at 0x0C. The shadow period is at 0x10 and the shadow compare value is at 0x14. A 16-bit control word is at 0x2A, which is the upper half of the word at 0x28. When `bus_wide`=1, the access moves the whole 32-bit word at `bus_addr[5:2]`. When `bus_wide`=0, the access moves the halfword chosen by `bus_addr[1]`, and the data travels in bits 15:0. Read data appears on `bus_rdata` one cycle after `bus_rd`. Narrow reads return zero in bits 31:16.
- R3: While the run bit (control bit 4) is set, the counter steps from 0 up to period−1 and then returns to 0. A period value of 0 or 1 holds the counter at 0.
- R4: While the run bit is clear, the counter is held at 0. Setting the bit again restarts the count from 0.
- R5: `pwm_out` is registered. In the cycle after a given counter value, the output equals (mode bit 9 set) AND (counter < active compare value).
- R6: When the mode bit (control bit 9) is clear, `pwm_out` is low.
- R7: A compare value equal to or greater than the period keeps the output high for the whole period. A compare value of 0 keeps the output low.
- R8: A write to a shadow register leaves the active values unchanged until the period in progress ends. In the cycle the counter wraps, both shadow values are copied into the active registers.
- R9: The copy at a period end happens only if a shadow register was written since the previous copy. A value written directly to an active register is therefore not overwritten later by stale shadow contents.
- R10: Control bits 7:6 (sync source) are stored and read back, but they have no effect on the counter or the output.
- R11: With a period of 1 and a compare value of 1 while running in PWM mode, the output stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data; narrow writes use bits 15:0 |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
The hardest case to reach is a shadow transfer that meets other traffic on the exact cycle the counter wraps. Examples are a direct write to an active register, or a new shadow write, landing on the same edge as the copy. A second hard case is a period end that finds no pending shadow value. The stimulus writes shadow values at arbitrary points inside running periods, rewrites an active register directly just after a copy, and then shrinks the period. As a result, several wraps occur both with and without pending loads. A cycle-accurate behavioural model compares `pwm_out` on every clock. Because of that comparison, any early, late, missing or repeated copy shows up as a waveform difference.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  // word indices (byte offset / 4) of the register bank
  localparam int WORD_PRD_ACT = 2;
  localparam int WORD_CMP_ACT = 3;
  localparam int WORD_PRD_SHD = 4;
  localparam int WORD_CMP_SHD = 5;
  localparam int WORD_CTRL    = 10;
  // control word bit positions
  localparam int CTRL_RUN_BIT  = 4;
  localparam int CTRL_MODE_BIT = 9;
  // number of timing registers (active pair + shadow pair)
  localparam int NUM_TREGS = 4;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_wide,
  input  logic [DW-1:0] bus_wdata,
  input  logic          period_end,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] prd_act,
  output logic [DW-1:0] cmp_act,
  output logic          ctrl_run,
  output logic          ctrl_mode
);
  localparam int HW   = DW / 2;
  localparam int WSEL = AW - 2;

  logic [WSEL-1:0] word;
  logic [DW-1:0]   wmask, wdat, rword;
  logic [DW-1:0]   val_q [NUM_TREGS];
  logic [NUM_TREGS-1:0] hit;
  logic [CW-1:0]   ctrl_q;
  logic            pend_q, shadow_wr, load, ctrl_hit;

  assign word = bus_addr[AW-1:2];

  // lane steering for 16/32-bit accesses
  always_comb begin
    if (bus_wide) begin
      wmask = '1;
      wdat  = bus_wdata;
    end else begin
      wdat  = {bus_wdata[HW-1:0], bus_wdata[HW-1:0]};
      wmask = bus_addr[1] ? {{HW{1'b1}}, {HW{1'b0}}} : {{HW{1'b0}}, {HW{1'b1}}};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_TREGS; g++) begin : g_hit
      assign hit[g] = bus_wr && (word == WSEL'(WORD_PRD_ACT + g));
    end
  endgenerate

  assign ctrl_hit  = bus_wr && (word == WSEL'(WORD_CTRL));
  assign shadow_wr = hit[WORD_PRD_SHD-WORD_PRD_ACT] | hit[WORD_CMP_SHD-WORD_PRD_ACT];
  assign load      = period_end && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TREGS; i++) val_q[i] <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (load) begin
        val_q[0] <= val_q[2];
        val_q[1] <= val_q[3];
      end
      // a bus write on the same edge overrides the transfer
      for (int i = 0; i < NUM_TREGS; i++)
        if (hit[i]) val_q[i] <= (val_q[i] & ~wmask) | (wdat & wmask);
      if (ctrl_hit)
        ctrl_q <= (ctrl_q & ~wmask[DW-1:HW]) | (wdat[DW-1:HW] & wmask[DW-1:HW]);
      pend_q <= shadow_wr ? 1'b1 : (load ? 1'b0 : pend_q);
    end
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < NUM_TREGS; i++)
      if (word == WSEL'(WORD_PRD_ACT + i)) rword = val_q[i];
    if (word == WSEL'(WORD_CTRL)) rword = {ctrl_q, {(DW-CW){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= bus_wide ? rword
                 : {{HW{1'b0}}, (bus_addr[1] ? rword[DW-1:HW] : rword[HW-1:0])};
  end

  assign prd_act   = val_q[0];
  assign cmp_act   = val_q[1];
  assign ctrl_run  = ctrl_q[CTRL_RUN_BIT];
  assign ctrl_mode = ctrl_q[CTRL_MODE_BIT];

  // active values only move on a direct write or a pending transfer
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!hit[0] && !hit[1] && !(period_end && pend_q)) |=> ($stable(prd_act) && $stable(cmp_act)));

  // a transfer consumes the pending load
  assert_pending_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (period_end && pend_q && !shadow_wr) |=> !pend_q);

  // a shadow write always leaves a load pending
  assert_pending_set_R9: assert property (@(posedge clk) disable iff (rst)
    shadow_wr |=> pend_q);
endmodule

// File: rtl/apwm_core.sv
module apwm_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          mode,
  input  logic [DW-1:0] prd,
  input  logic [DW-1:0] cmp,
  output logic          period_end,
  output logic          pwm_out
);
  logic [DW-1:0] cnt_q;
  logic [DW:0]   nxt;

  assign nxt        = {1'b0, cnt_q} + {{DW{1'b0}}, 1'b1};
  assign period_end = run && (nxt >= {1'b0, prd});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt_q   <= (!run || period_end) ? '0 : nxt[DW-1:0];
      pwm_out <= mode && (cnt_q < cmp);
    end
  end

  assert_stop_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (cnt_q == '0));

  assert_mode_low_R6: assert property (@(posedge clk) disable iff (rst)
    !mode |=> !pwm_out);

  assert_zero_cmp_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp == '0) |=> !pwm_out);
endmodule

// File: rtl/apwm_shadow.sv
module apwm_shadow #(
  parameter int DW = 32,
  parameter int AW = 6,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_wide,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  logic [DW-1:0] prd_act, cmp_act;
  logic          run, mode, period_end;

  apwm_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .period_end(period_end),
    .bus_rdata(bus_rdata), .prd_act(prd_act), .cmp_act(cmp_act),
    .ctrl_run(run), .ctrl_mode(mode)
  );

  apwm_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .prd(prd_act), .cmp(cmp_act),
    .period_end(period_end), .pwm_out(pwm_out)
  );
endmodule

// File: tb/apwm_shadow_test.sv
module apwm_shadow_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, bus_wide = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0, errors = 0;
  string phase = "R1";

  apwm_shadow uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  // behavioural reference: m_reg[0..3] = active prd, active cmp, shadow prd, shadow cmp
  logic [31:0] m_reg [4];
  logic [15:0] m_ctrl;
  logic [31:0] m_cnt;
  logic        m_pend, m_out;

  always @(posedge clk) begin : model
    logic [32:0] nx;
    logic        pe, ld;
    logic [31:0] msk, dat;
    int          wi;
    wi = bus_addr[5:2];
    if (rst) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
      m_ctrl = 0; m_cnt = 0; m_pend = 0; m_out = 0;
    end else begin
      nx = {1'b0, m_cnt} + 33'd1;
      pe = m_ctrl[4] && (nx >= {1'b0, m_reg[0]});
      ld = pe && m_pend;
      m_out = m_ctrl[9] && (m_cnt < m_reg[1]);
      m_cnt = (!m_ctrl[4] || pe) ? 32'd0 : nx[31:0];
      if (ld) begin m_reg[0] = m_reg[2]; m_reg[1] = m_reg[3]; end
      if (bus_wr) begin
        if (bus_wide) begin msk = 32'hFFFF_FFFF; dat = bus_wdata; end
        else begin
          dat = {bus_wdata[15:0], bus_wdata[15:0]};
          msk = bus_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
        end
        if (wi >= 2 && wi <= 5) m_reg[wi-2] = (m_reg[wi-2] & ~msk) | (dat & msk);
        if (wi == 10) m_ctrl = (m_ctrl & ~msk[31:16]) | (dat[31:16] & msk[31:16]);
      end
      m_pend = (bus_wr && (wi == 4 || wi == 5)) ? 1'b1 : (ld ? 1'b0 : m_pend);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle waveform comparison
  always @(negedge clk) if (!rst) check(pwm_out === m_out, phase, {31'b0, pwm_out}, {31'b0, m_out});

  task automatic wr(input logic [5:0] a, input bit w, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wide = w; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input bit w, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_wide = w; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(pwm_out === 1'b0, "R1", {31'b0, pwm_out}, 0);
    rd_chk(6'h08, 1, 0, "R1");
    rd_chk(6'h0C, 1, 0, "R1");
    rd_chk(6'h10, 1, 0, "R1");
    rd_chk(6'h14, 1, 0, "R1");
    rd_chk(6'h2A, 0, 0, "R1");

    // R2: map and access widths
    phase = "R2";
    wr(6'h08, 1, 32'h1234_5678);
    wr(6'h0A, 0, 32'h0000_BEEF);
    rd_chk(6'h08, 1, 32'hBEEF_5678, "R2");
    rd_chk(6'h08, 0, 32'h0000_5678, "R2");
    rd_chk(6'h0A, 0, 32'h0000_BEEF, "R2");
    wr(6'h14, 1, 32'hA5A5_0003);
    rd_chk(6'h14, 1, 32'hA5A5_0003, "R2");
    wr(6'h2A, 0, 32'h0000_0200);
    rd_chk(6'h28, 1, 32'h0200_0000, "R2");

    // R5/R3: basic waveform, period 10, compare 3
    phase = "R5";
    wr(6'h08, 1, 10);
    wr(6'h0C, 1, 3);
    wr(6'h14, 1, 3);
    wr(6'h2A, 0, 16'h0210);
    idle(40);

    // R8: shadow writes mid-period
    phase = "R8";
    idle(4);
    wr(6'h10, 1, 6);
    wr(6'h14, 1, 4);
    idle(30);
    rd_chk(6'h08, 1, 6, "R8");

    // R9: direct active write after transfer survives later wraps
    phase = "R9";
    wr(6'h0C, 1, 1);
    idle(30);
    rd_chk(6'h0C, 1, 1, "R9");

    // R7: compare >= period, then compare 0
    phase = "R7";
    wr(6'h0C, 1, 20);
    idle(20);
    wr(6'h0C, 1, 0);
    idle(20);
    wr(6'h0C, 1, 6);
    idle(12);

    // R6: mode clear
    phase = "R6";
    wr(6'h0C, 1, 2);
    wr(6'h2A, 0, 16'h0010);
    idle(20);

    // R10: sync bits stored, no effect
    phase = "R10";
    wr(6'h2A, 0, 16'h02D0);
    idle(20);
    rd_chk(6'h2A, 0, 32'h0000_02D0, "R10");

    // R4: stop then restart from zero
    phase = "R4";
    wr(6'h2A, 0, 16'h0200);
    idle(10);
    wr(6'h10, 1, 5);
    wr(6'h14, 1, 2);
    wr(6'h2A, 0, 16'h0210);
    idle(25);

    // R3: period 0 holds counter at zero
    phase = "R3";
    wr(6'h2A, 0, 16'h0200);
    wr(6'h08, 1, 0);
    wr(6'h0C, 1, 1);
    wr(6'h2A, 0, 16'h0210);
    idle(10);

    // R11: minimum period
    phase = "R11";
    wr(6'h2A, 0, 16'h0200);
    wr(6'h08, 1, 1);
    wr(6'h0C, 1, 1);
    wr(6'h2A, 0, 16'h0210);
    idle(10);
    check(pwm_out === 1'b1, "R11", {31'b0, pwm_out}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule